// File: doc/BRIEF.md
# Write-Completion Probe Sequencer for a Serial EEPROM

This block runs on the controller side of a two-wire serial bus. It waits for a serial EEPROM to finish its self-timed internal write. Software or a higher-level engine hands the block a device address as soon as a write command has been closed with a stop condition. From then on the block drives a separate bit-level bus engine. That engine takes start, stop and byte-send commands and reports, for each byte sent, whether the target acknowledged it.

Each probe is a start condition followed by the device's control byte with the read/write bit cleared. While the memory is still programming it does not acknowledge, so the block treats a missing acknowledge as "busy". It then closes the bus with a stop, waits a programmable number of idle cycles, and probes again. The first acknowledge means the write is finished. The block then returns a success result together with the number of probes it used. Depending on a per-request mode bit, it either leaves the bus open after the start so the next command can continue directly, or it releases the bus with a stop. If no acknowledge arrives within a parameterised number of probes, the block reports a timeout instead.

Top module: `i2c_ack_poller`

## Requirements
- R1: After reset, req_ready is 1, res_valid is 0 and cmd_valid is 0.
- R2: In the cycle after a request is accepted (req_valid and req_ready both high at a clock edge), the block presents a START command (cmd_op = 0) without any wait.
- R3: Every START command of a probe is followed by a byte-send command (cmd_op = 2) whose cmd_data is the request's 7-bit device address in bits 7:1 with bit 0 (read/write) at 0.
- R4: After a byte that got no acknowledge (eng_ack = 0 with eng_done), and if the probe limit is not reached, the block issues a STOP (cmd_op = 1). The next START is presented exactly gap_cycles + 1 clock edges after the edge at which that STOP's eng_done is taken. gap_cycles is sampled when the request is accepted.
- R5: When a probe byte is acknowledged, the result carries res_err = 0 and res_tries equal to the number of probes made, counting the acknowledged one.
- R6: With req_hold_bus = 1, no STOP follows the acknowledged probe and the result follows directly. With req_hold_bus = 0, exactly one STOP is issued after the acknowledged probe and before the result.
- R7: If MAX_TRIES probes in a row are not acknowledged, the block issues one STOP and reports res_err = 1 with res_tries = MAX_TRIES. It starts no further probe.
- R8: req_ready is 0 from acceptance until the result is taken. Address and gap inputs changed after acceptance have no effect. res_valid, res_err and res_tries stay steady until res_ready is high.
- R9: While cmd_valid is high and cmd_ready is low, cmd_valid, cmd_op and cmd_data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start-polling request valid |
| req_ready | output | 1 | Block can accept a request |
| req_dev_addr | input | ADDR_W | 7-bit device address to probe |
| req_hold_bus | input | 1 | 1: keep bus after ACK, 0: end with STOP |
| gap_cycles | input | GAP_W | Idle cycles inserted between probes |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result accepted |
| res_err | output | 1 | 1: timeout, no acknowledge seen |
| res_tries | output | TRY_W | Number of probes made |
| cmd_valid | output | 1 | Bus-engine command valid |
| cmd_ready | input | 1 | Bus engine takes the command |
| cmd_op | output | 2 | 0 START, 1 STOP, 2 byte send |
| cmd_data | output | 8 | Byte to send with cmd_op = 2 |
| eng_done | input | 1 | One-cycle pulse: command finished |
| eng_ack | input | 1 | With eng_done after a byte: 1 acknowledged |

## Verification
The hardest situations to reach from the ports are the probe-limit boundary and the exact spacing between a busy STOP and the next START. The bench stands in for the bus engine with a modelled memory that stays busy for a chosen number of probes. It sets that number to one below the limit, equal to the limit and above it, and so reaches both the last-chance success and the timeout. It times each STOP completion against the following START to the clock edge, using several gap values. The gap and address inputs are scrambled right after acceptance to show that they were latched.

// File: rtl/apoll_pkg.sv
package apoll_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2
  } bus_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START_REQ,
    S_START_WAIT,
    S_ADDR_REQ,
    S_ADDR_WAIT,
    S_STOP_REQ,
    S_STOP_WAIT,
    S_GAP,
    S_REPORT
  } seq_state_e;
endpackage

// File: rtl/apoll_rst_sync.sv
module apoll_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/apoll_gap_timer.sv
module apoll_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  input  logic             en,
  output logic             expired
);
  logic [GAP_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                       cnt_d = load_val;
    else if (en && (cnt_q != '0))   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R4
  gap_count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && !expired) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/apoll_try_counter.sv
module apoll_try_counter #(
  parameter int MAX_TRIES = 16,
  parameter int TRY_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [TRY_W-1:0] count,
  output logic             last_try
);
  logic [TRY_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count    = cnt_q;
  assign last_try = (cnt_q == TRY_W'(MAX_TRIES - 1));

  // R7
  try_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TRY_W'(MAX_TRIES));
endmodule

// File: rtl/apoll_seq.sv
module apoll_seq
  import apoll_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_dev_addr,
  input  logic              req_hold_bus,
  input  logic [GAP_W-1:0]  gap_cycles,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_err,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W:0]   cmd_data,
  input  logic              eng_done,
  input  logic              eng_ack,
  output logic              try_clr,
  output logic              try_inc,
  input  logic              try_last,
  output logic              gap_load,
  output logic [GAP_W-1:0]  gap_val,
  output logic              gap_en,
  input  logic              gap_expired
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] dev_q, dev_d;
  logic              hold_q, hold_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic              ok_q, ok_d;
  logic              err_q, err_d;

  always_comb begin
    state_d   = state_q;
    dev_d     = dev_q;
    hold_d    = hold_q;
    gap_d     = gap_q;
    ok_d      = ok_q;
    err_d     = err_q;
    req_ready = 1'b0;
    res_valid = 1'b0;
    cmd_valid = 1'b0;
    cmd_op    = OP_START;
    cmd_data  = '0;
    try_clr   = 1'b0;
    try_inc   = 1'b0;
    gap_load  = 1'b0;
    gap_en    = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          dev_d   = req_dev_addr;
          hold_d  = req_hold_bus;
          gap_d   = gap_cycles;
          ok_d    = 1'b0;
          err_d   = 1'b0;
          try_clr = 1'b1;
          state_d = S_START_REQ;
        end
      end
      S_START_REQ: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_START;
        if (cmd_ready) state_d = S_START_WAIT;
      end
      S_START_WAIT: begin
        if (eng_done) state_d = S_ADDR_REQ;
      end
      S_ADDR_REQ: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_WRITE;
        cmd_data  = {dev_q, 1'b0};
        if (cmd_ready) state_d = S_ADDR_WAIT;
      end
      S_ADDR_WAIT: begin
        if (eng_done) begin
          try_inc = 1'b1;
          if (eng_ack) begin
            ok_d    = 1'b1;
            state_d = hold_q ? S_REPORT : S_STOP_REQ;
          end else begin
            err_d   = try_last;
            state_d = S_STOP_REQ;
          end
        end
      end
      S_STOP_REQ: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_STOP;
        if (cmd_ready) state_d = S_STOP_WAIT;
      end
      S_STOP_WAIT: begin
        if (eng_done) begin
          if (ok_q || err_q) begin
            state_d = S_REPORT;
          end else begin
            gap_load = 1'b1;
            state_d  = S_GAP;
          end
        end
      end
      S_GAP: begin
        gap_en = 1'b1;
        if (gap_expired) state_d = S_START_REQ;
      end
      S_REPORT: begin
        res_valid = 1'b1;
        if (res_ready) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      dev_q   <= '0;
      hold_q  <= 1'b0;
      gap_q   <= '0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dev_q   <= dev_d;
      hold_q  <= hold_d;
      gap_q   <= gap_d;
      ok_q    <= ok_d;
      err_q   <= err_d;
    end
  end

  assign gap_val = gap_q;
  assign res_err = err_q;

  // R2
  start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd_valid && cmd_op == OP_START));

  // R9
  cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_data)));

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_err)));

  // R6
  hold_no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ADDR_WAIT && eng_done && eng_ack && hold_q) |=> (res_valid && !cmd_valid));
endmodule

// File: rtl/i2c_ack_poller.sv
module i2c_ack_poller #(
  parameter  int MAX_TRIES = 16,
  parameter  int GAP_W     = 8,
  parameter  int ADDR_W    = 7,
  localparam int TRY_W     = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_dev_addr,
  input  logic              req_hold_bus,
  input  logic [GAP_W-1:0]  gap_cycles,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_err,
  output logic [TRY_W-1:0]  res_tries,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W:0]   cmd_data,
  input  logic              eng_done,
  input  logic              eng_ack
);
  logic             rst_n_int;
  logic             try_clr, try_inc, try_last;
  logic             gap_load, gap_en, gap_expired;
  logic [GAP_W-1:0] gap_val;

  apoll_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  apoll_seq #(.ADDR_W(ADDR_W), .GAP_W(GAP_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_dev_addr (req_dev_addr),
    .req_hold_bus (req_hold_bus),
    .gap_cycles   (gap_cycles),
    .res_valid    (res_valid),
    .res_ready    (res_ready),
    .res_err      (res_err),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_op       (cmd_op),
    .cmd_data     (cmd_data),
    .eng_done     (eng_done),
    .eng_ack      (eng_ack),
    .try_clr      (try_clr),
    .try_inc      (try_inc),
    .try_last     (try_last),
    .gap_load     (gap_load),
    .gap_val      (gap_val),
    .gap_en       (gap_en),
    .gap_expired  (gap_expired)
  );

  apoll_try_counter #(.MAX_TRIES(MAX_TRIES), .TRY_W(TRY_W)) u_tries (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .clr      (try_clr),
    .inc      (try_inc),
    .count    (res_tries),
    .last_try (try_last)
  );

  apoll_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (gap_load),
    .load_val (gap_val),
    .en       (gap_en),
    .expired  (gap_expired)
  );

  // R7
  res_tries_range_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    res_valid |-> (res_tries >= TRY_W'(1) && res_tries <= TRY_W'(MAX_TRIES)));
endmodule

// File: tb/i2c_ack_poller_tb.sv
module i2c_ack_poller_tb;
  localparam int MAXT  = 5;
  localparam int TW    = $clog2(MAXT + 1);

  typedef struct {
    bit err;
    int tries;
    int stops;
    int starts;
  } exp_t;

  logic          clk, rst_n;
  logic          req_valid, req_ready, req_hold_bus;
  logic [6:0]    req_dev_addr;
  logic [7:0]    gap_cycles;
  logic          res_valid, res_ready, res_err;
  logic [TW-1:0] res_tries;
  logic          cmd_valid, cmd_ready, eng_done, eng_ack;
  logic [1:0]    cmd_op;
  logic [7:0]    cmd_data;

  int   n_tests, n_fail, cyc;
  int   busy_polls, polls_seen, stops_seen, starts_seen, gap_exp, stop_cyc;
  bit   after_stop, first_pending, finished;
  logic [6:0] exp_addr;
  exp_t sb_q[$];

  i2c_ack_poller #(.MAX_TRIES(MAXT), .GAP_W(8), .ADDR_W(7)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_dev_addr(req_dev_addr),
    .req_hold_bus(req_hold_bus), .gap_cycles(gap_cycles),
    .res_valid(res_valid), .res_ready(res_ready), .res_err(res_err), .res_tries(res_tries),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .eng_done(eng_done), .eng_ack(eng_ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Bus-engine and memory model
  initial begin
    cmd_ready = 1'b0; eng_done = 1'b0; eng_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid) begin
        logic [1:0] op;
        bit         ack_now;
        op = cmd_op;
        ack_now = 1'b0;
        if (first_pending) begin
          chk(op == 2'd0, "R2 first command START", op, 0);
          first_pending = 1'b0;
        end
        if (op == 2'd0) begin
          starts_seen++;
          if (after_stop)
            chk(cyc - stop_cyc == gap_exp + 2, "R4 STOP-to-START spacing", cyc - stop_cyc, gap_exp + 2);
          after_stop = 1'b0;
        end else if (op == 2'd2) begin
          chk(cmd_data == {exp_addr, 1'b0}, "R3 control byte", cmd_data, {exp_addr, 1'b0});
          ack_now = (polls_seen >= busy_polls);
          polls_seen++;
        end else begin
          stops_seen++;
        end
        repeat (polls_seen % 2) @(negedge clk);
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        repeat (2) @(negedge clk);
        eng_done = 1'b1;
        eng_ack  = (op == 2'd2) ? ack_now : 1'b0;
        if (op == 2'd1) begin
          stop_cyc   = cyc;
          after_stop = 1'b1;
        end
        @(negedge clk);
        eng_done = 1'b0;
        eng_ack  = 1'b0;
      end
    end
  end

  // Scoreboard monitor
  always @(posedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R5 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(res_err == e.err, e.err ? "R7 timeout flag" : "R5 success flag", res_err, e.err);
        chk(int'(res_tries) == e.tries, e.err ? "R7 probe count" : "R5 probe count", res_tries, e.tries);
        chk(stops_seen == e.stops, "R6 STOP count", stops_seen, e.stops);
        chk(starts_seen == e.starts, "R7 START count", starts_seen, e.starts);
      end
    end
  end

  task automatic run_poll(input logic [6:0] addr, input bit hold, input int gap,
                          input int busy, input int stall);
    exp_t e;
    @(negedge clk);
    busy_polls = busy; polls_seen = 0; stops_seen = 0; starts_seen = 0;
    after_stop = 1'b0; first_pending = 1'b1; exp_addr = addr; gap_exp = gap;
    e.err    = (busy >= MAXT);
    e.tries  = e.err ? MAXT : busy + 1;
    e.stops  = e.err ? MAXT : busy + (hold ? 0 : 1);
    e.starts = e.tries;
    sb_q.push_back(e);
    chk(req_ready == 1'b1, "R8 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_dev_addr = addr; req_hold_bus = hold; gap_cycles = 8'(gap);
    @(negedge clk);
    req_valid = 1'b0; req_dev_addr = ~addr; req_hold_bus = ~hold; gap_cycles = 8'hFF;
    chk(req_ready == 1'b0, "R8 not ready while busy", req_ready, 0);
    while (!res_valid) @(negedge clk);
    begin
      logic          e0;
      logic [TW-1:0] t0;
      e0 = res_err; t0 = res_tries;
      for (int i = 0; i < stall; i++) begin
        @(negedge clk);
        chk(res_valid && res_err == e0 && res_tries == t0, "R8 result held", res_tries, t0);
      end
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(res_valid == 1'b0, "R8 result released", res_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    n_tests = 0; n_fail = 0; cyc = 0; finished = 1'b0;
    busy_polls = 0; polls_seen = 0; stops_seen = 0; starts_seen = 0;
    gap_exp = 0; stop_cyc = 0; after_stop = 1'b0; first_pending = 1'b0; exp_addr = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_dev_addr = '0; req_hold_bus = 1'b0;
    gap_cycles = '0; res_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
    chk(res_valid == 1'b0, "R1 res_valid after reset", res_valid, 0);
    chk(cmd_valid == 1'b0, "R1 cmd_valid after reset", cmd_valid, 0);

    run_poll(7'h50, 1'b1, 0,  0, 0);   // R5 R6 immediate ACK, bus held
    run_poll(7'h51, 1'b0, 3,  3, 2);   // R4 R6 busy then ACK, final STOP
    run_poll(7'h2A, 1'b1, 10, 2, 1);   // R4 longer gap, bus held
    run_poll(7'h7F, 1'b0, 1,  9, 3);   // R7 never acknowledged
    run_poll(7'h00, 1'b0, 0,  MAXT-1, 0); // R5 ACK on last allowed probe
    run_poll(7'h15, 1'b1, 2,  MAXT, 1);   // R7 exactly at the limit
    repeat (5) @(negedge clk);
    chk(cmd_valid == 1'b0, "R7 idle after timeout", cmd_valid, 0);
    chk(sb_q.size() == 0, "R5 all results seen", sb_q.size(), 0);
    finish_run();
  end
endmodule